// File: doc/BRIEF.md
# Interrupt Acknowledge and Nested Completion Unit

This block is the per-processor end of an interrupt controller. A separate selector presents the best pending interrupt (its 10-bit ID and 8-bit priority). When the processor takes an interrupt, the block decides whether the offered interrupt may preempt the one already running. If it may, the block returns its ID, asks the pending storage to drop its pending bit, and makes it the running interrupt. The ID 1023 means "no interrupt", both as an answer and as the running state.

Each interrupt has a link entry that records which interrupt it preempted and at what priority. Together the entries form a preemption stack rooted at the running interrupt. Completing the running interrupt pops that stack. Completing an interrupt deeper in the stack is also legal. In that case a small state machine walks the links, one entry per clock, and splices the completed entry out. While the walk runs the block reports busy and drops any new request. At completion, a level-sensitive interrupt whose line is still high is handed back to the pending storage as a re-pend request.

States: `S_IDLE` accepts requests. A completion of a non-running interrupt moves it to `S_WALK`. `S_WALK` steps one link per cycle. It returns to `S_IDLE` when it finds the link that points to the completed ID (and rewrites that link) or when it reaches a link of 1023.

Top module: `irq_ack_eoi_unit`

## Requirements
- R1: An accepted acknowledge is rejected if `pend_id` is not below `NUM_IRQ` (1023 included) or if `{1'b0,pend_prio}` is not strictly below `run_prio`. A rejected acknowledge returns `ack_id` = 1023, raises no `clr_pend` and leaves `run_id`/`run_prio` unchanged.
- R2: A winning acknowledge saves the current running ID and priority as the link of `pend_id`, sets `run_id` = `pend_id` and `run_prio` = `pend_prio`, and pulses `clr_pend` with `clr_id` = `pend_id`. `ack_done` and the other results appear in the cycle after the accepting edge.
- R3: After reset `run_id` = 1023 and `run_prio` = 0x100. Whenever `run_id` is 1023, `run_prio` is 0x100.
- R4: With `clr_pend`, `clr_all` equals bit `pend_id` of `irq_one_to_n` (1 = clear for all processors, 0 = this processor only).
- R5: An EOI with `eoi_id` at or above `NUM_IRQ` (1023 included), or an EOI while `run_id` is 1023, changes nothing, raises no `repend` and does not make the block busy.
- R6: An EOI that is not ignored pulses `repend` with `repend_id` = `eoi_id` in the next cycle exactly when bit `eoi_id` is 0 in `irq_edge` (0 = level, 1 = edge) and 1 in each of `irq_enable`, `irq_line` and `irq_to_me`.
- R7: An EOI of the running interrupt restores `run_id`/`run_prio` from its link in the next cycle.
- R8: An EOI of a non-running interrupt leaves `run_id`/`run_prio` unchanged. If the ID is in the chain, it is removed, so that a later completion passes over it. If it is not in the chain, the chain is untouched.
- R9: `busy` is high from the cycle after a splice EOI until the walk ends. An acknowledge or EOI sampled while `busy` is high is dropped (no `ack_done`).
- R10: When `ack_req` and `eoi_req` are sampled together while not busy, the acknowledge is served and the EOI is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ack_req | input | 1 | Acknowledge strobe, one cycle |
| pend_id | input | 10 | Highest pending ID from the selector (1023 = none) |
| pend_prio | input | 8 | Priority of `pend_id` (lower = stronger) |
| eoi_req | input | 1 | End-of-interrupt strobe, one cycle |
| eoi_id | input | 10 | ID being completed |
| irq_edge | input | NUM_IRQ | Per-ID trigger mode, 1 = edge, 0 = level |
| irq_enable | input | NUM_IRQ | Per-ID enable |
| irq_line | input | NUM_IRQ | Per-ID current input level |
| irq_to_me | input | NUM_IRQ | Per-ID: targeted at this processor |
| irq_one_to_n | input | NUM_IRQ | Per-ID handling model, 1 = one-of-many |
| ack_done | output | 1 | Acknowledge answered (one cycle) |
| ack_id | output | 10 | Acknowledged ID, or 1023 |
| clr_pend | output | 1 | Clear-pending request (one cycle) |
| clr_id | output | 10 | ID to clear |
| clr_all | output | 1 | Clear for all processors |
| repend | output | 1 | Re-pend request (one cycle) |
| repend_id | output | 10 | ID to set pending again |
| run_id | output | 10 | Running interrupt ID (1023 = idle) |
| run_prio | output | 9 | Running priority (0x100 when idle) |
| busy | output | 1 | Chain walk in progress |

## Verification
The assertions assume that the selector offers only IDs below `NUM_IRQ` or 1023, and that an ID's priority does not change while that ID is in the preemption chain. Under these conditions an ID already in the chain is never acknowledged again, and the links cannot form a loop. The stimulus keeps within both assumptions. It fixes each ID's priority in a table at start-up and takes `pend_prio` from that table. It sends requests during `busy` only in directed cases, where the dropped response is what is being checked.

// File: rtl/iae_pkg.sv
package iae_pkg;
    localparam int ID_W       = 10;
    localparam int PRIO_W     = 8;
    localparam int RPRIO_W    = PRIO_W + 1;
    localparam logic [ID_W-1:0]    ID_NONE   = 10'd1023;
    localparam logic [RPRIO_W-1:0] PRIO_IDLE = 9'h100;

    typedef struct packed {
        logic [ID_W-1:0]    id;
        logic [RPRIO_W-1:0] prio;
    } link_t;

    typedef enum logic [0:0] {
        S_IDLE = 1'b0,
        S_WALK = 1'b1
    } walk_state_t;
endpackage

// File: rtl/iae_link_store.sv
module iae_link_store
    import iae_pkg::*;
#(
    parameter int NUM_IRQ = 64,
    parameter int IDX_W   = $clog2(NUM_IRQ)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  link_t            wr_data,
    input  logic [IDX_W-1:0] rd_run_idx,
    output link_t            rd_run,
    input  logic [IDX_W-1:0] rd_walk_idx,
    output link_t            rd_walk,
    input  logic [IDX_W-1:0] rd_tgt_idx,
    output link_t            rd_tgt
);
    link_t ent [NUM_IRQ];

    for (genvar g = 0; g < NUM_IRQ; g++) begin : g_ent
        link_t ent_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ent_q <= '{id: ID_NONE, prio: PRIO_IDLE};
            end else if (wr_en && wr_idx == IDX_W'(g)) begin
                ent_q <= wr_data;
            end
        end
        assign ent[g] = ent_q;
    end

    assign rd_run  = ent[rd_run_idx];
    assign rd_walk = ent[rd_walk_idx];
    assign rd_tgt  = ent[rd_tgt_idx];

    // R2: a write never targets an entry outside the ID range
    p_wr_in_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (int'(wr_idx) < NUM_IRQ));
endmodule

// File: rtl/iae_repend_check.sv
module iae_repend_check #(
    parameter int NUM_IRQ = 64,
    parameter int IDX_W   = $clog2(NUM_IRQ)
) (
    input  logic [IDX_W-1:0]   idx,
    input  logic [NUM_IRQ-1:0] irq_edge,
    input  logic [NUM_IRQ-1:0] irq_enable,
    input  logic [NUM_IRQ-1:0] irq_line,
    input  logic [NUM_IRQ-1:0] irq_to_me,
    output logic               hit
);
    always_comb begin
        hit = !irq_edge[idx] && irq_enable[idx] && irq_line[idx] && irq_to_me[idx];
    end
endmodule

// File: rtl/iae_seq.sv
module iae_seq
    import iae_pkg::*;
#(
    parameter int NUM_IRQ = 64,
    parameter int IDX_W   = $clog2(NUM_IRQ)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ack_req,
    input  logic [ID_W-1:0]     pend_id,
    input  logic [PRIO_W-1:0]   pend_prio,
    input  logic                eoi_req,
    input  logic [ID_W-1:0]     eoi_id,
    input  logic                pend_one_to_n,
    input  logic                repend_hit,
    output logic                lk_wr_en,
    output logic [IDX_W-1:0]    lk_wr_idx,
    output link_t               lk_wr_data,
    output logic [IDX_W-1:0]    lk_run_idx,
    input  link_t               lk_run,
    output logic [IDX_W-1:0]    lk_walk_idx,
    input  link_t               lk_walk,
    output logic [IDX_W-1:0]    lk_tgt_idx,
    input  link_t               lk_tgt,
    output logic                ack_done,
    output logic [ID_W-1:0]     ack_id,
    output logic                clr_pend,
    output logic [ID_W-1:0]     clr_id,
    output logic                clr_all,
    output logic                repend,
    output logic [ID_W-1:0]     repend_id,
    output logic [ID_W-1:0]     run_id,
    output logic [RPRIO_W-1:0]  run_prio,
    output logic                busy
);
    localparam logic [ID_W-1:0] ID_LIMIT = ID_W'(NUM_IRQ);

    walk_state_t        state_q, state_d;
    logic [ID_W-1:0]    run_id_q;
    logic [RPRIO_W-1:0] run_prio_q;
    logic [IDX_W-1:0]   walk_cur_q;
    logic [ID_W-1:0]    walk_tgt_q;

    logic take_ack, take_eoi, ack_win, eoi_live, eoi_pop, eoi_walk;
    logic walk_end, walk_found, walking;

    always_comb begin
        walking    = (state_q == S_WALK);
        take_ack   = ack_req && !walking;
        take_eoi   = eoi_req && !walking && !ack_req;
        ack_win    = take_ack && (pend_id < ID_LIMIT) && (pend_id != ID_NONE)
                     && ({1'b0, pend_prio} < run_prio_q);
        eoi_live   = take_eoi && (eoi_id < ID_LIMIT) && (run_id_q != ID_NONE);
        eoi_pop    = eoi_live && (eoi_id == run_id_q);
        eoi_walk   = eoi_live && !eoi_pop;
        walk_end   = (lk_walk.id == ID_NONE);
        walk_found = !walk_end && (lk_walk.id == walk_tgt_q);
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: if (eoi_walk) state_d = S_WALK;
            S_WALK: if (walk_end || walk_found) state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // Running interrupt and walk pointers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_id_q   <= ID_NONE;
            run_prio_q <= PRIO_IDLE;
            walk_cur_q <= '0;
            walk_tgt_q <= ID_NONE;
        end else begin
            if (ack_win) begin
                run_id_q   <= pend_id;
                run_prio_q <= {1'b0, pend_prio};
            end else if (eoi_pop) begin
                run_id_q   <= lk_run.id;
                run_prio_q <= lk_run.prio;
            end
            if (eoi_walk) begin
                walk_cur_q <= run_id_q[IDX_W-1:0];
                walk_tgt_q <= eoi_id;
            end else if (walking && !walk_end && !walk_found) begin
                walk_cur_q <= lk_walk.id[IDX_W-1:0];
            end
        end
    end

    // Link table access
    always_comb begin
        lk_run_idx  = run_id_q[IDX_W-1:0];
        lk_walk_idx = walk_cur_q;
        lk_tgt_idx  = walk_tgt_q[IDX_W-1:0];
        lk_wr_en    = ack_win || (walking && walk_found);
        lk_wr_idx   = ack_win ? pend_id[IDX_W-1:0] : walk_cur_q;
        lk_wr_data  = ack_win ? '{id: run_id_q, prio: run_prio_q} : lk_tgt;
    end

    // Registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ack_done  <= 1'b0;
            ack_id    <= ID_NONE;
            clr_pend  <= 1'b0;
            clr_id    <= ID_NONE;
            clr_all   <= 1'b0;
            repend    <= 1'b0;
            repend_id <= ID_NONE;
        end else begin
            ack_done <= take_ack;
            ack_id   <= ack_win ? pend_id : ID_NONE;
            clr_pend <= ack_win;
            if (ack_win) begin
                clr_id  <= pend_id;
                clr_all <= pend_one_to_n;
            end
            repend <= eoi_live && repend_hit;
            if (eoi_live) repend_id <= eoi_id;
        end
    end

    assign run_id   = run_id_q;
    assign run_prio = run_prio_q;
    assign busy     = walking;

    // R3: idle running ID always goes with the idle priority
    p_idle_prio_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (run_id_q == ID_NONE) |-> (run_prio_q == PRIO_IDLE));

    // R1: an acknowledge with no pending ID is answered with 1023 and no change
    p_reject_none_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_req && !busy && pend_id == ID_NONE)
        |=> (ack_done && ack_id == ID_NONE && !clr_pend && $stable(run_id_q)));

    // R2: a strictly stronger pending ID becomes the running one
    p_win_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_req && !busy && pend_id < ID_LIMIT && {1'b0, pend_prio} < run_prio_q)
        |=> (clr_pend && run_id_q == $past(pend_id) && ack_id == $past(pend_id)));

    // R5: an out-of-range completion has no effect
    p_eoi_ignore_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_req && !ack_req && !busy && eoi_id >= ID_LIMIT)
        |=> ($stable(run_id_q) && !busy && !repend));

    // R9: an acknowledge during a walk is dropped
    p_busy_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && ack_req) |=> (!ack_done && $stable(run_id_q)));

    // R10: simultaneous requests serve only the acknowledge
    p_both_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_req && eoi_req && !busy) |=> (ack_done && !repend && !busy));

    // R8: a walk never alters the running interrupt
    p_walk_keeps_run_r8: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(run_id_q));
endmodule

// File: rtl/irq_ack_eoi_unit.sv
module irq_ack_eoi_unit
    import iae_pkg::*;
#(
    parameter int NUM_IRQ = 64
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ack_req,
    input  logic [9:0]         pend_id,
    input  logic [7:0]         pend_prio,
    input  logic               eoi_req,
    input  logic [9:0]         eoi_id,
    input  logic [NUM_IRQ-1:0] irq_edge,
    input  logic [NUM_IRQ-1:0] irq_enable,
    input  logic [NUM_IRQ-1:0] irq_line,
    input  logic [NUM_IRQ-1:0] irq_to_me,
    input  logic [NUM_IRQ-1:0] irq_one_to_n,
    output logic               ack_done,
    output logic [9:0]         ack_id,
    output logic               clr_pend,
    output logic [9:0]         clr_id,
    output logic               clr_all,
    output logic               repend,
    output logic [9:0]         repend_id,
    output logic [9:0]         run_id,
    output logic [8:0]         run_prio,
    output logic               busy
);
    localparam int IDX_W = $clog2(NUM_IRQ);

    logic             lk_wr_en;
    logic [IDX_W-1:0] lk_wr_idx, lk_run_idx, lk_walk_idx, lk_tgt_idx;
    link_t            lk_wr_data, lk_run, lk_walk, lk_tgt;
    logic             repend_hit;

    iae_link_store #(.NUM_IRQ(NUM_IRQ), .IDX_W(IDX_W)) u_links (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (lk_wr_en),
        .wr_idx     (lk_wr_idx),
        .wr_data    (lk_wr_data),
        .rd_run_idx (lk_run_idx),
        .rd_run     (lk_run),
        .rd_walk_idx(lk_walk_idx),
        .rd_walk    (lk_walk),
        .rd_tgt_idx (lk_tgt_idx),
        .rd_tgt     (lk_tgt)
    );

    iae_repend_check #(.NUM_IRQ(NUM_IRQ), .IDX_W(IDX_W)) u_repend (
        .idx       (eoi_id[IDX_W-1:0]),
        .irq_edge  (irq_edge),
        .irq_enable(irq_enable),
        .irq_line  (irq_line),
        .irq_to_me (irq_to_me),
        .hit       (repend_hit)
    );

    iae_seq #(.NUM_IRQ(NUM_IRQ), .IDX_W(IDX_W)) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .ack_req      (ack_req),
        .pend_id      (pend_id),
        .pend_prio    (pend_prio),
        .eoi_req      (eoi_req),
        .eoi_id       (eoi_id),
        .pend_one_to_n(irq_one_to_n[pend_id[IDX_W-1:0]]),
        .repend_hit   (repend_hit),
        .lk_wr_en     (lk_wr_en),
        .lk_wr_idx    (lk_wr_idx),
        .lk_wr_data   (lk_wr_data),
        .lk_run_idx   (lk_run_idx),
        .lk_run       (lk_run),
        .lk_walk_idx  (lk_walk_idx),
        .lk_walk      (lk_walk),
        .lk_tgt_idx   (lk_tgt_idx),
        .lk_tgt       (lk_tgt),
        .ack_done     (ack_done),
        .ack_id       (ack_id),
        .clr_pend     (clr_pend),
        .clr_id       (clr_id),
        .clr_all      (clr_all),
        .repend       (repend),
        .repend_id    (repend_id),
        .run_id       (run_id),
        .run_prio     (run_prio),
        .busy         (busy)
    );
endmodule

// File: tb/irq_ack_eoi_unit_tb.sv
`timescale 1ns/1ps
module irq_ack_eoi_unit_tb;
    localparam int N = 64;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ack_req = 1'b0, eoi_req = 1'b0;
    logic [9:0] pend_id = 10'd1023, eoi_id = 10'd1023;
    logic [7:0] pend_prio = 8'd0;
    logic [N-1:0] irq_edge = '0, irq_enable = '0, irq_line = '0, irq_to_me = '0, irq_one_to_n = '0;
    logic ack_done, clr_pend, clr_all, repend, busy;
    logic [9:0] ack_id, clr_id, repend_id, run_id;
    logic [8:0] run_prio;

    always #4 clk = ~clk;

    irq_ack_eoi_unit #(.NUM_IRQ(N)) u_dut (
        .clk(clk), .rst_n(rst_n), .ack_req(ack_req), .pend_id(pend_id), .pend_prio(pend_prio),
        .eoi_req(eoi_req), .eoi_id(eoi_id), .irq_edge(irq_edge), .irq_enable(irq_enable),
        .irq_line(irq_line), .irq_to_me(irq_to_me), .irq_one_to_n(irq_one_to_n),
        .ack_done(ack_done), .ack_id(ack_id), .clr_pend(clr_pend), .clr_id(clr_id),
        .clr_all(clr_all), .repend(repend), .repend_id(repend_id), .run_id(run_id),
        .run_prio(run_prio), .busy(busy)
    );

    int n_checks = 0, n_errors = 0;
    bit finished = 0;
    int m_run_id, m_run_pr;
    int m_lk_id [N];
    int m_lk_pr [N];
    int prio_of [N];

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    endtask

    task automatic check_run(input string tag);
        chk(int'(run_id) == m_run_id, tag, int'(run_id), m_run_id);
        chk(int'(run_prio) == m_run_pr, tag, int'(run_prio), m_run_pr);
        if (m_run_id == 1023) chk(run_prio == 9'h100, "R3 idle priority", int'(run_prio), 256);
    endtask

    task automatic wait_free();
        for (int n = 0; busy; n++) begin
            if (n > 2000) begin
                chk(0, "R9 walk did not end", 1, 0);
                finish_run();
            end
            @(negedge clk);
        end
    endtask

    task automatic randomize_cfg();
        irq_edge     = {$urandom(), $urandom()};
        irq_enable   = {$urandom(), $urandom()} | {$urandom(), $urandom()};
        irq_line     = {$urandom(), $urandom()} | {$urandom(), $urandom()};
        irq_to_me    = {$urandom(), $urandom()} | {$urandom(), $urandom()};
        irq_one_to_n = {$urandom(), $urandom()};
    endtask

    // Expected results of an acknowledge, then model update
    task automatic expect_ack(input int pid, input int pr);
        bit win;
        win = (pid < N) && (pr < m_run_pr);
        chk(ack_done == 1'b1, "R2 ack_done one cycle after request", int'(ack_done), 1);
        if (win) begin
            chk(int'(ack_id) == pid, "R2 ack_id", int'(ack_id), pid);
            chk(clr_pend == 1'b1, "R2 clr_pend", int'(clr_pend), 1);
            chk(int'(clr_id) == pid, "R2 clr_id", int'(clr_id), pid);
            chk(clr_all == irq_one_to_n[pid], "R4 clr_all", int'(clr_all), int'(irq_one_to_n[pid]));
            m_lk_id[pid] = m_run_id;
            m_lk_pr[pid] = m_run_pr;
            m_run_id = pid;
            m_run_pr = pr;
            check_run("R2 running after win");
        end else begin
            chk(ack_id == 10'd1023, "R1 rejected ack_id", int'(ack_id), 1023);
            chk(clr_pend == 1'b0, "R1 rejected clr_pend", int'(clr_pend), 0);
            check_run("R1 running unchanged");
        end
    endtask

    task automatic do_ack(input int pid, input int pr);
        wait_free();
        ack_req = 1'b1; pend_id = 10'(pid); pend_prio = 8'(pr);
        @(negedge clk);
        ack_req = 1'b0;
        expect_ack(pid, pr);
    endtask

    task automatic do_both(input int pid, input int pr, input int eid);
        wait_free();
        ack_req = 1'b1; pend_id = 10'(pid); pend_prio = 8'(pr);
        eoi_req = 1'b1; eoi_id = 10'(eid);
        @(negedge clk);
        ack_req = 1'b0; eoi_req = 1'b0;
        chk(repend == 1'b0, "R10 eoi dropped: no repend", int'(repend), 0);
        chk(busy == 1'b0, "R10 eoi dropped: not busy", int'(busy), 0);
        expect_ack(pid, pr);
    endtask

    task automatic do_eoi(input int eid, input bit poke);
        bit live, exp_rp, is_run;
        int cur;
        wait_free();
        live   = (eid < N) && (m_run_id != 1023);
        is_run = live && (eid == m_run_id);
        exp_rp = live && !irq_edge[eid] && irq_enable[eid] && irq_line[eid] && irq_to_me[eid];
        eoi_req = 1'b1; eoi_id = 10'(eid);
        @(negedge clk);
        eoi_req = 1'b0;
        chk(repend == exp_rp, "R6 repend", int'(repend), int'(exp_rp));
        if (exp_rp) chk(int'(repend_id) == eid, "R6 repend_id", int'(repend_id), eid);
        if (!live) chk(busy == 1'b0, "R5 ignored eoi not busy", int'(busy), 0);
        else chk(busy == !is_run, "R9 busy after splice eoi", int'(busy), int'(!is_run));
        if (poke && busy) begin
            ack_req = 1'b1; pend_id = 10'd0; pend_prio = 8'd0;
            @(negedge clk);
            ack_req = 1'b0;
            chk(ack_done == 1'b0, "R9 ack during walk dropped", int'(ack_done), 0);
        end
        wait_free();
        if (!live) begin
            check_run("R5 ignored eoi");
        end else if (is_run) begin
            m_run_id = m_lk_id[eid];
            m_run_pr = m_lk_pr[eid];
            check_run("R7 pop restores link");
        end else begin
            cur = m_run_id;
            while (m_lk_id[cur] != 1023) begin
                if (m_lk_id[cur] == eid) begin
                    m_lk_id[cur] = m_lk_id[eid];
                    m_lk_pr[cur] = m_lk_pr[eid];
                    break;
                end
                cur = m_lk_id[cur];
            end
            check_run("R8 splice keeps running");
        end
    endtask

    function automatic int chain_len();
        int c = 0;
        for (int id = m_run_id; id != 1023; id = m_lk_id[id]) c++;
        return c;
    endfunction

    function automatic int chain_at(input int k);
        int id = m_run_id;
        for (int i = 0; i < k; i++) id = m_lk_id[id];
        return id;
    endfunction

    initial begin
        #(8 * 150000);
        chk(0, "watchdog expired", 1, 0);
        finish_run();
    end

    initial begin
        void'($urandom(32'd20240611));
        m_run_id = 1023; m_run_pr = 256;
        for (int i = 0; i < N; i++) begin
            m_lk_id[i] = 1023; m_lk_pr[i] = 256;
            prio_of[i] = int'($urandom() % 256);
        end
        prio_of[3] = 100; prio_of[9] = 100; prio_of[5] = 40; prio_of[7] = 10;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_run("R3 reset state");
        chk(busy == 1'b0, "R3 reset busy", int'(busy), 0);
        chk(ack_done == 1'b0, "R3 reset ack_done", int'(ack_done), 0);

        // Directed corners
        randomize_cfg();
        do_eoi(5, 0);                       // R5 idle completion
        do_ack(1023, 0);                    // R1 nothing pending
        do_ack(3, prio_of[3]);              // R2 first win
        do_ack(9, prio_of[9]);              // R1 equal priority rejected
        do_eoi(1023, 0);                    // R5 spurious id
        do_eoi(200, 0);                     // R5 out of range
        do_ack(5, prio_of[5]);              // R2 nested win
        do_eoi(3, 1);                       // R8 splice, R9 drop during walk
        do_eoi(5, 0);                       // R7 pop passes over spliced 3 -> idle
        chk(run_id == 10'd1023, "R8 spliced entry skipped", int'(run_id), 1023);
        do_both(7, prio_of[7], 1023);       // R10
        irq_edge[7] = 1'b0; irq_enable[7] = 1'b1; irq_line[7] = 1'b1; irq_to_me[7] = 1'b1;
        do_eoi(7, 0);                       // R6 level re-pend, R7 pop to idle
        do_ack(7, prio_of[7]);
        irq_edge[7] = 1'b1;
        do_eoi(7, 0);                       // R6 edge: no re-pend

        // Constrained random
        for (int op = 0; op < 1500; op++) begin
            int r, k, pid, eid;
            randomize_cfg();
            r = int'($urandom() % 100);
            pid = ($urandom() % 10 == 0) ? 1023 : int'($urandom() % N);
            if (r < 45) begin
                do_ack(pid, pid < N ? prio_of[pid] : int'($urandom() % 256));
            end else if (r < 90) begin
                k = int'($urandom() % 10);
                if (k == 0) eid = 1023;
                else if (k == 1) eid = N + int'($urandom() % (1023 - N));
                else if (k < 4 || chain_len() == 0) eid = int'($urandom() % N);
                else eid = chain_at(int'($urandom() % chain_len()));
                do_eoi(eid, ($urandom() % 4) == 0);
            end else begin
                do_both(pid, pid < N ? prio_of[pid] : 0, int'($urandom() % N));
            end
        end

        // Drain the chain
        while (m_run_id != 1023) do_eoi(m_run_id, 0);
        check_run("R7 drained to idle");
        finish_run();
    end
endmodule